// File: doc/BRIEF.md
# Branch Record Ring Buffer

This block keeps a short history of taken control-flow transfers reported by a processor core. Each transfer arrives as a one-cycle strobe that carries its source and target addresses, a branch class and a privilege flag. The class and privilege are already decoded when they arrive. A qualifying transfer is written into a circular file of from/to registers, and a pointer register always names the newest record. Software reads the history back through a simple register port. It can also write the pointer and the entries, which lets it restore a saved stack.

A select register filters what is logged. Each of its low nine bits suppresses either one privilege level or one branch class. Its top bit turns on call-stack mode: calls push a record and returns pop the pointer, so the buffer tracks the live call chain. A control register enables capture and can arm a freeze that stops logging when an interrupt is raised, so the history is preserved until the interrupt is acknowledged. The freeze never takes effect in call-stack mode. With the flag format enabled, mispredict and transaction flags are packed into the three top bits of each stored from word.

Top module: `brr_top`

## Requirements
- R1: After reset, every from and to entry, the pointer (address 0x02), the control register (0x00) and the select register (0x01) read as zero.
- R2: When capture is enabled and not suppressed, a branch strobe writes its record at index (pointer+1) mod DEPTH and advances the pointer, so that the pointer names the newest record. The record k places back sits at (pointer − k) & (DEPTH − 1). From words are read at 0x40+i and to words at 0x80+i.
- R3: While control bit 0 (enable) is clear, strobes leave the entries and the pointer unchanged.
- R4: Select bit 0 suppresses strobes whose privilege input br_kern is 1 (ring 0). Select bit 1 suppresses strobes with br_kern = 0.
- R5: Select bit 2+c suppresses class c, where the class code is: 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch. Code 7 is always suppressed.
- R6: With the flag format, bit 63 of a stored from word holds mispredict, bit 62 holds in-transaction, bit 61 holds abort, and bits 60:0 hold the address.
- R7: Address 0xC0+i returns from entry i with bit 60 copied into bits 63:61 (sign-extended address, flags stripped).
- R8: With control bit 1 (freeze-on-interrupt) and enable set, an irq pulse sets the frozen state, which reads back as control bit 2. While frozen, no record is written and the pointer does not move. An irq_ack pulse clears the frozen state and takes priority over irq.
- R9: With select bit 9 set (call-stack mode), an unsuppressed call (class 1 or 2) pushes a record as in R2. An unsuppressed return (class 3) moves the pointer back by one without writing. All other classes are ignored.
- R10: In call-stack mode an irq never sets the frozen state.
- R11: Software writes to the pointer and the entries take effect on the next cycle. A pointer write in the same cycle as a capture wins over the capture's pointer update, while the capture's record is still written at the old pointer+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | One-cycle strobe for a taken transfer |
| br_class | input | 3 | Branch class code (see R5) |
| br_kern | input | 1 | 1 when the target runs at ring 0 |
| br_from | input | 64 | Source address |
| br_to | input | 64 | Target address |
| br_mispred | input | 1 | Transfer was mispredicted |
| br_in_tx | input | 1 | Transfer occurred inside a transaction |
| br_abort | input | 1 | Transfer was a transaction abort |
| irq | input | 1 | Performance interrupt raised |
| irq_ack | input | 1 | Interrupt acknowledged, unfreezes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |

## Verification
The hardest state to reach from the ports is the combination of freeze, call-stack mode and pointer wrap-around. A freeze that is armed while call-stack mode is on must stay inert, and returns that pop past index zero must wrap the pointer to DEPTH−1. The directed part of the bench sets these cases up explicitly. The random part mixes irq and acknowledge pulses, select patterns that switch call-stack mode on and off, and streams of calls and returns. This drives the pointer across both wrap directions while freezes come and go. A same-cycle pointer write and capture is forced once, to pin down the priority rule.

// File: rtl/brr_pkg.sv
// Package: shared types and constants for the branch record ring buffer.
// Assumes a 64-bit record word with the three flag bits at the top.
package brr_pkg;
    localparam int W           = 64;
    localparam int SEL_W       = 10;
    localparam int SEL_RING0   = 0;
    localparam int SEL_RINGN   = 1;
    localparam int SEL_CLS_LO  = 2;
    localparam int SEL_CS_BIT  = 9;
    localparam int FLAG_LO     = 61;

    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_SEL  = 8'h01;
    localparam logic [7:0] ADDR_TOS  = 8'h02;
    localparam logic [1:0] RGN_FROM  = 2'b01;
    localparam logic [1:0] RGN_TO    = 2'b10;
    localparam logic [1:0] RGN_VIEW  = 2'b11;

    typedef enum logic [2:0] {
        CLS_COND  = 3'd0,
        CLS_RCALL = 3'd1,
        CLS_ICALL = 3'd2,
        CLS_RET   = 3'd3,
        CLS_IJMP  = 3'd4,
        CLS_RJMP  = 3'd5,
        CLS_FAR   = 3'd6,
        CLS_BAD   = 3'd7
    } br_class_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } act_e;
endpackage

// File: rtl/brr_filter.sv
// Module: decides what a branch strobe does to the ring.
// Applies privilege and class suppression, then maps the class onto
// push/pop/none according to the call-stack mode bit. Purely combinational.
module brr_filter
    import brr_pkg::*;
(
    input  logic             br_valid,
    input  logic [2:0]       br_class,
    input  logic             br_kern,
    input  logic             capture_on,
    input  logic [SEL_W-1:0] sel,
    output act_e             act
);
    logic priv_block;
    logic cls_block;
    logic is_call;
    logic is_ret;

    // Privilege and class suppression lookup.
    always_comb begin
        priv_block = br_kern ? sel[SEL_RING0] : sel[SEL_RINGN];
        case (br_class)
            CLS_COND:  cls_block = sel[SEL_CLS_LO + 0];
            CLS_RCALL: cls_block = sel[SEL_CLS_LO + 1];
            CLS_ICALL: cls_block = sel[SEL_CLS_LO + 2];
            CLS_RET:   cls_block = sel[SEL_CLS_LO + 3];
            CLS_IJMP:  cls_block = sel[SEL_CLS_LO + 4];
            CLS_RJMP:  cls_block = sel[SEL_CLS_LO + 5];
            CLS_FAR:   cls_block = sel[SEL_CLS_LO + 6];
            default:   cls_block = 1'b1;
        endcase
        is_call = (br_class == CLS_RCALL) || (br_class == CLS_ICALL);
        is_ret  = (br_class == CLS_RET);
    end

    // Action selection for the ring.
    always_comb begin
        act = ACT_NONE;
        if (br_valid && capture_on && !priv_block && !cls_block) begin
            if (sel[SEL_CS_BIT]) begin
                if (is_call)     act = ACT_PUSH;
                else if (is_ret) act = ACT_POP;
            end else begin
                act = ACT_PUSH;
            end
        end
    end
endmodule

// File: rtl/brr_freeze.sv
// Module: frozen-state flag for freeze-on-interrupt.
// Sets on irq only when capture is enabled, freeze is armed and
// call-stack mode is off; an acknowledge clears it and wins over irq.
module brr_freeze (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic irq_ack,
    input  logic enable,
    input  logic frz_arm,
    input  logic cs_mode,
    output logic frozen
);
    // Frozen flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  frozen <= 1'b0;
        else if (irq_ack)                            frozen <= 1'b0;
        else if (irq && enable && frz_arm && !cs_mode) frozen <= 1'b1;
    end
endmodule

// File: rtl/brr_ring.sv
// Module: circular from/to register file with the top-of-stack pointer.
// A push writes at tos+1 and advances; a pop steps back without writing.
// Software writes to entries lose to a capture on the same index;
// a software pointer write wins over the capture's pointer update.
module brr_ring
    import brr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic [W-1:0]     cap_from,
    input  logic [W-1:0]     cap_to,
    input  logic             sw_we_from,
    input  logic             sw_we_to,
    input  logic             sw_we_tos,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [W-1:0]     sw_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_from,
    output logic [W-1:0]     rd_to,
    output logic [IDX_W-1:0] tos
);
    logic [W-1:0]     from_q [DEPTH];
    logic [W-1:0]     to_q   [DEPTH];
    logic [IDX_W-1:0] widx;

    assign widx = tos + 1'b1;

    // Pointer update: software write, push, pop.
    always_ff @(posedge clk) begin
        if (!rst_n)               tos <= '0;
        else if (sw_we_tos)       tos <= sw_data[IDX_W-1:0];
        else if (act == ACT_PUSH) tos <= tos + 1'b1;
        else if (act == ACT_POP)  tos <= tos - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Entry g: capture first, then software restore.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                from_q[g] <= '0;
                to_q[g]   <= '0;
            end else if (act == ACT_PUSH && widx == IDX_W'(g)) begin
                from_q[g] <= cap_from;
                to_q[g]   <= cap_to;
            end else if (sw_idx == IDX_W'(g)) begin
                if (sw_we_from) from_q[g] <= sw_data;
                if (sw_we_to)   to_q[g]   <= sw_data;
            end
        end
    end

    assign rd_from = from_q[rd_idx];
    assign rd_to   = to_q[rd_idx];
endmodule

// File: rtl/brr_top.sv
// Module: branch record ring buffer top level with register port.
// Map: 0x00 control {frozen(ro), freeze-arm, enable}, 0x01 select,
// 0x02 pointer, 0x40+i from, 0x80+i to, 0xC0+i sign-extended from (ro).
// Assumes DEPTH is a power of two between 4 and 32.
module brr_top
    import brr_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter bit FLAG_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_valid,
    input  logic [2:0]  br_class,
    input  logic        br_kern,
    input  logic [63:0] br_from,
    input  logic [63:0] br_to,
    input  logic        br_mispred,
    input  logic        br_in_tx,
    input  logic        br_abort,
    input  logic        irq,
    input  logic        irq_ack,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             ctrl_en;
    logic             ctrl_frz;
    logic [SEL_W-1:0] sel_q;
    logic             frozen;
    act_e             act;
    logic [IDX_W-1:0] tos;
    logic [W-1:0]     cap_from;
    logic [W-1:0]     rd_from;
    logic [W-1:0]     rd_to;
    logic [W-1:0]     rd_view;
    logic             in_range;
    logic [IDX_W-1:0] ent_idx;
    logic             hit_from;
    logic             hit_to;
    logic             hit_view;
    logic             we_tos;

    // Address decode.
    assign in_range = ((reg_addr[5:0] >> IDX_W) == 6'd0);
    assign ent_idx  = reg_addr[IDX_W-1:0];
    assign hit_from = (reg_addr[7:6] == RGN_FROM) && in_range;
    assign hit_to   = (reg_addr[7:6] == RGN_TO)   && in_range;
    assign hit_view = (reg_addr[7:6] == RGN_VIEW) && in_range;
    assign we_tos   = reg_we && (reg_addr == ADDR_TOS);

    // Control and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_frz <= 1'b0;
            sel_q    <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) begin
                ctrl_en  <= reg_wdata[0];
                ctrl_frz <= reg_wdata[1];
            end
            if (reg_addr == ADDR_SEL) sel_q <= reg_wdata[SEL_W-1:0];
        end
    end

    if (FLAG_EN) begin : g_flags
        assign cap_from = {br_mispred, br_in_tx, br_abort, br_from[FLAG_LO-1:0]};
        assign rd_view  = {{(W-FLAG_LO){rd_from[FLAG_LO-1]}}, rd_from[FLAG_LO-1:0]};
    end else begin : g_plain
        assign cap_from = br_from;
        assign rd_view  = rd_from;
    end

    brr_freeze u_freeze (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (irq),
        .irq_ack (irq_ack),
        .enable  (ctrl_en),
        .frz_arm (ctrl_frz),
        .cs_mode (sel_q[SEL_CS_BIT]),
        .frozen  (frozen)
    );

    brr_filter u_filter (
        .br_valid   (br_valid),
        .br_class   (br_class),
        .br_kern    (br_kern),
        .capture_on (ctrl_en && !frozen),
        .sel        (sel_q),
        .act        (act)
    );

    brr_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .cap_from   (cap_from),
        .cap_to     (br_to),
        .sw_we_from (reg_we && hit_from),
        .sw_we_to   (reg_we && hit_to),
        .sw_we_tos  (we_tos),
        .sw_idx     (ent_idx),
        .sw_data    (reg_wdata),
        .rd_idx     (ent_idx),
        .rd_from    (rd_from),
        .rd_to      (rd_to),
        .tos        (tos)
    );

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL)     reg_rdata = {61'd0, frozen, ctrl_frz, ctrl_en};
        else if (reg_addr == ADDR_SEL) reg_rdata = {{(W-SEL_W){1'b0}}, sel_q};
        else if (reg_addr == ADDR_TOS) reg_rdata = {{(W-IDX_W){1'b0}}, tos};
        else if (hit_from)             reg_rdata = rd_from;
        else if (hit_to)               reg_rdata = rd_to;
        else if (hit_view)             reg_rdata = rd_view;
    end
endmodule

// File: rtl/brr_chk.sv
// Module: property checker bound to brr_top; observes the pointer,
// the ring action and the frozen flag across the submodule boundaries.
module brr_chk
    import brr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input act_e             act,
    input logic [IDX_W-1:0] tos,
    input logic             frozen,
    input logic             sel_cs,
    input logic             ctrl_en,
    input logic             irq_ack,
    input logic             we_tos
);
    AST_PUSH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_PUSH && !we_tos) |=> tos == IDX_W'($past(tos) + 1'b1)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE && !we_tos) |=> $stable(tos)); // R3
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> act == ACT_NONE); // R3
    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> act == ACT_NONE); // R8
    AST_ACK_UNFREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !frozen); // R8
    AST_POP_RETREATS: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_POP && !we_tos) |=> tos == IDX_W'($past(tos) - 1'b1)); // R9
    AST_POP_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_POP |-> sel_cs); // R9
    AST_CS_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cs && !frozen) |=> !frozen); // R10
endmodule

bind brr_top brr_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .tos     (tos),
    .frozen  (frozen),
    .sel_cs  (sel_q[SEL_CS_BIT]),
    .ctrl_en (ctrl_en),
    .irq_ack (irq_ack),
    .we_tos  (we_tos)
);

// File: tb/tb_brr_top.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a behavioural model kept in bench variables.
module tb_brr_top;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [2:0]  br_class = '0;
    logic        br_kern = 1'b0;
    logic [63:0] br_from = '0;
    logic [63:0] br_to = '0;
    logic        br_mispred = 1'b0;
    logic        br_in_tx = 1'b0;
    logic        br_abort = 1'b0;
    logic        irq = 1'b0;
    logic        irq_ack = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] m_from [D];
    logic [63:0] m_to   [D];
    int          m_tos;
    bit          m_en, m_frz, m_frozen;
    logic [9:0]  m_sel;

    brr_top #(.DEPTH(D), .FLAG_EN(1'b1)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, logic [63:0] exp, string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a == 8'h00) begin m_en = d[0]; m_frz = d[1]; end
        else if (a == 8'h01) m_sel = d[9:0];
        else if (a == 8'h02) m_tos = int'(d[3:0]);
        else if (a[7:6] == 2'b01 && a[5:4] == 2'b00) m_from[a[3:0]] = d;
        else if (a[7:6] == 2'b10 && a[5:4] == 2'b00) m_to[a[3:0]] = d;
    endtask

    function automatic bit m_supp(int cls, bit kern);
        if (cls > 6) return 1'b1;
        return (kern ? m_sel[0] : m_sel[1]) | m_sel[2 + cls];
    endfunction

    // Model of one strobe; returns nothing, updates model state.
    task automatic m_branch(int cls, bit kern, logic [63:0] f, logic [63:0] t,
                            bit mis, bit tx, bit ab);
        if (!m_en || m_frozen || m_supp(cls, kern)) return;
        if (m_sel[9]) begin
            if (cls == 1 || cls == 2) begin
                m_tos = (m_tos + 1) % D;
                m_from[m_tos] = {mis, tx, ab, f[60:0]};
                m_to[m_tos] = t;
            end else if (cls == 3) m_tos = (m_tos + D - 1) % D;
        end else begin
            m_tos = (m_tos + 1) % D;
            m_from[m_tos] = {mis, tx, ab, f[60:0]};
            m_to[m_tos] = t;
        end
    endtask

    task automatic drive_br(int cls, bit kern, logic [63:0] f, logic [63:0] t,
                            bit mis, bit tx, bit ab);
        br_valid = 1'b1; br_class = 3'(cls); br_kern = kern;
        br_from = f; br_to = t; br_mispred = mis; br_in_tx = tx; br_abort = ab;
    endtask

    task automatic br(int cls, bit kern, logic [63:0] f, logic [63:0] t,
                      bit mis, bit tx, bit ab);
        drive_br(cls, kern, f, t, mis, tx, ab);
        @(posedge clk); #1;
        br_valid = 1'b0;
        m_branch(cls, kern, f, t, mis, tx, ab);
    endtask

    task automatic irq_pulse(bit i, bit a);
        irq = i; irq_ack = a;
        @(posedge clk); #1;
        irq = 1'b0; irq_ack = 1'b0;
        if (a) m_frozen = 1'b0;
        else if (i && m_en && m_frz && !m_sel[9]) m_frozen = 1'b1;
    endtask

    task automatic check_all(string req);
        rd(8'h02, 64'(m_tos), req);
        for (int i = 0; i < D; i++) begin
            rd(8'h40 + 8'(i), m_from[i], req);
            rd(8'h80 + 8'(i), m_to[i], req);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom} | 64'h1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] sel_pool [6];
        logic [63:0] a;
        sel_pool = '{10'h000, 10'h001, 10'h002, 10'h0a4, 10'h200, 10'h25c};
        void'($urandom(32'h0bad_5eed));
        for (int i = 0; i < D; i++) begin m_from[i] = '0; m_to[i] = '0; end
        m_tos = 0; m_en = 0; m_frz = 0; m_frozen = 0; m_sel = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, 64'd0, "R1");
        rd(8'h01, 64'd0, "R1");
        check_all("R1");

        // R3: disabled, strobe ignored
        br(0, 0, 64'h1000, 64'h2000, 0, 0, 0);
        rd(8'h02, 64'd0, "R3");
        rd(8'h41, 64'd0, "R3");

        // R2: normal capture, then wrap-around
        wr(8'h00, 64'h1);
        for (int i = 0; i < 3; i++) br(i, i[0], 64'h100 + 64'(i), 64'h200 + 64'(i), 0, 0, 0);
        rd(8'h02, 64'd3, "R2");
        rd(8'h43, 64'h102, "R2");
        for (int i = 0; i < 17; i++) br(5, 0, 64'h3000 + 64'(i), 64'h4000 + 64'(i), 0, 0, 0);
        rd(8'h02, 64'(20 % D), "R2");
        check_all("R2");

        // R4: privilege suppression
        wr(8'h01, 64'h001);
        br(0, 1, 64'h5000, 64'h5001, 0, 0, 0);
        rd(8'h02, 64'(m_tos), "R4");
        br(0, 0, 64'h5100, 64'h5101, 0, 0, 0);
        rd(8'h02, 64'(m_tos), "R4");
        rd(8'h40 + 8'(m_tos), 64'h5100, "R4");

        // R5: class suppression of relative jumps (select bit 7)
        wr(8'h01, 64'h080);
        br(5, 0, 64'h6000, 64'h6001, 0, 0, 0);
        br(7, 0, 64'h6100, 64'h6101, 0, 0, 0);
        br(4, 1, 64'h6200, 64'h6201, 0, 0, 0);
        check_all("R5");

        // R6/R7: flag packing and sign-extended view
        wr(8'h01, 64'h000);
        a = 64'h1000_0000_0000_abcd;
        br(6, 1, a, 64'h77, 1, 0, 1);
        rd(8'h40 + 8'(m_tos), {3'b101, a[60:0]}, "R6");
        rd(8'hC0 + 8'(m_tos), {3'b111, a[60:0]}, "R7");
        br(1, 0, 64'h0abc, 64'h78, 0, 1, 0);
        rd(8'h40 + 8'(m_tos), {3'b010, 61'h0abc}, "R6");
        rd(8'hC0 + 8'(m_tos), 64'h0abc, "R7");

        // R8: freeze on interrupt, acknowledge releases
        wr(8'h00, 64'h3);
        irq_pulse(1, 0);
        rd(8'h00, 64'h7, "R8");
        br(0, 0, 64'h8000, 64'h8001, 0, 0, 0);
        rd(8'h02, 64'(m_tos), "R8");
        irq_pulse(1, 1);
        rd(8'h00, 64'h3, "R8");
        br(0, 0, 64'h8100, 64'h8101, 0, 0, 0);
        check_all("R8");

        // R9/R10: call-stack mode, pop wraps below zero
        wr(8'h01, 64'h200);
        wr(8'h02, 64'h0);
        br(1, 0, 64'h9000, 64'h9001, 0, 0, 0);
        br(2, 0, 64'h9100, 64'h9101, 0, 0, 0);
        rd(8'h02, 64'd2, "R9");
        br(3, 0, 64'h9200, 64'h9201, 0, 0, 0);
        br(0, 0, 64'h9300, 64'h9301, 0, 0, 0);
        rd(8'h02, 64'd1, "R9");
        br(3, 0, 64'h9400, 64'h9401, 0, 0, 0);
        br(3, 0, 64'h9500, 64'h9501, 0, 0, 0);
        rd(8'h02, 64'(D - 1), "R9");
        irq_pulse(1, 0);
        rd(8'h00, 64'h3, "R10");
        br(1, 1, 64'h9600, 64'h9601, 0, 0, 0);
        check_all("R9");

        // R11: software restore and same-cycle priority
        wr(8'h01, 64'h000);
        wr(8'h02, 64'd9);
        wr(8'h45, 64'hdead);
        wr(8'h85, 64'hbeef);
        rd(8'h02, 64'd9, "R11");
        rd(8'h45, 64'hdead, "R11");
        rd(8'h85, 64'hbeef, "R11");
        drive_br(0, 0, 64'ha000, 64'ha001, 0, 0, 0);
        reg_addr = 8'h02; reg_wdata = 64'd4; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; br_valid = 1'b0;
        m_branch(0, 0, 64'ha000, 64'ha001, 0, 0, 0);
        m_tos = 4;
        check_all("R11");

        // Random traffic: R2 R4 R5 R8 R9 R10
        for (int it = 0; it < 600; it++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) irq_pulse(1, 0);
            else if (r == 1) irq_pulse(0, 1);
            else if (r == 2) wr(8'h01, 64'(sel_pool[$urandom % 6]));
            else if (r == 3) wr(8'h00, 64'(($urandom % 4) | 1));
            else br(int'($urandom % 8), 1'($urandom), rnd64(), rnd64(),
                    1'($urandom), 1'($urandom), 1'($urandom));
            rd(8'h02, 64'(m_tos), "R2 random pointer");
            rd(8'h00, {61'd0, m_frozen, m_frz, m_en}, "R8 random control");
        end
        check_all("R9 random final");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule